// File: doc/BRIEF.md
# Return Stack with Paired Address Counters

This unit holds the return addresses of a stack-machine core. The newest return address sits in a register (the top-of-return entry, TOR). Older entries live in a private two-port RAM that no other part of the core can reach. One opcode is applied each clock, and every operation completes in that clock. A call pushes the current instruction pointer. A single return hands TOR back as the next instruction pointer. A double return discards one frame and hands back the frame below it.

Two up/down counters address the RAM. One holds the next free slot and the other holds the newest stored entry, and they always move together. This lets a double return read both entries it needs in the same cycle, one through each RAM port. The stack pointer can also be loaded directly. That load sets both counters at once, and the second counter takes the loaded value minus one. The pointers wrap modulo the RAM depth, and no overflow or underflow flag is produced.

Top module: `rstack_unit`

## Requirements
- R1: While rst_ni is low and after it rises, tor_o is 0 and sp_o is 0 until the first operation; next_ip_o equals ip_i whenever no return is taken.
- R2: Opcode 1 (push) stores the old TOR in the RAM at slot sp_o, loads ip_i into TOR and raises sp_o by one at the next clock edge; next_ip_o equals ip_i in that cycle.
- R3: Opcode 2 (single return) drives next_ip_o with TOR in the same cycle. At the next edge TOR takes the RAM entry at slot sp_o-1 and sp_o falls by one.
- R4: Opcode 3 (double return) drives next_ip_o with the RAM entry at slot sp_o-1 in the same cycle. At the next edge TOR takes the entry at slot sp_o-2 and sp_o falls by two.
- R5: Opcodes 4 and 5 are the conditional forms of opcodes 2 and 3. With cond_i high they act exactly as 2 and 3. With cond_i low, next_ip_o equals ip_i and TOR and sp_o keep their values.
- R6: Opcode 6 loads sp_load_i into sp_o at the next edge and leaves TOR unchanged. A following return reads the RAM entry at slot sp_load_i-1.
- R7: sp_o wraps modulo the RAM depth in both directions. A push at DEPTH-1 gives 0, a single return at 0 gives DEPTH-1, and a double return at 1 gives DEPTH-1.
- R8: Opcode 0 and the unused opcode 7 leave TOR and sp_o unchanged and drive next_ip_o with ip_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code (see R2 to R8) |
| cond_i | input | 1 | Condition for opcodes 4 and 5 |
| ip_i | input | DW | Current instruction pointer; value pushed by opcode 1 |
| sp_load_i | input | AW | New stack pointer for opcode 6 |
| next_ip_o | output | DW | Next instruction pointer (combinational) |
| tor_o | output | DW | Top-of-return register |
| sp_o | output | AW | Stack pointer (next free RAM slot) |

## Verification
next_ip_o is a combinational result. It is due in the same cycle the opcode is applied, so the bench drives inputs on the falling edge and samples next_ip_o 2 ns later, before the rising edge. TOR and sp_o are registered and are due one edge later, so they are sampled 1 ns after the rising edge that consumes the opcode. A reference array in the bench keeps track of the expected RAM contents, TOR and pointer. That reference runs through fixed sweeps: fill, wrap, every load value, and both condition values. A long pseudo-random opcode stream follows.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    RS_NOP     = 3'd0,
    RS_PUSH    = 3'd1,
    RS_RET     = 3'd2,
    RS_RET2    = 3'd3,
    RS_RET_IF  = 3'd4,
    RS_RET2_IF = 3'd5,
    RS_SET_SP  = 3'd6,
    RS_RSVD    = 3'd7
  } rs_op_e;

  typedef struct packed {
    logic push;
    logic pop1;
    logic pop2;
    logic load;
  } rs_ctl_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       cond_i,
  output rs_ctl_t    ctl_o
);
  rs_op_e op;
  assign op = rs_op_e'(op_i);

  always_comb begin
    ctl_o = '0;
    unique case (op)
      RS_PUSH:    ctl_o.push = 1'b1;
      RS_RET:     ctl_o.pop1 = 1'b1;
      RS_RET2:    ctl_o.pop2 = 1'b1;
      RS_RET_IF:  ctl_o.pop1 = cond_i;
      RS_RET2_IF: ctl_o.pop2 = cond_i;
      RS_SET_SP:  ctl_o.load = 1'b1;
      default:    ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/rs_ptr_counter.sv
module rs_ptr_counter #(
  parameter int unsigned AW = 4,
  parameter logic [AW-1:0] RST_VAL = '0,
  parameter logic [AW-1:0] LOAD_OFS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec1_i,
  input  logic          dec2_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] cnt_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i + LOAD_OFS;
    else if (inc_i)  cnt_d = cnt_q + ONE;
    else if (dec1_i) cnt_d = cnt_q - ONE;
    else if (dec2_i) cnt_d = cnt_q - TWO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RST_VAL;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rs_dpram.sv
module rs_dpram #(
  parameter int unsigned DW = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic          a_we_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic [AW-1:0] b_addr_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
  end

  assign a_rdata_o = mem_q[a_addr_i];
  assign b_rdata_o = mem_q[b_addr_i];
endmodule

// File: rtl/rstack_unit.sv
module rstack_unit
  import rs_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic          cond_i,
  input  logic [DW-1:0] ip_i,
  input  logic [AW-1:0] sp_load_i,
  output logic [DW-1:0] next_ip_o,
  output logic [DW-1:0] tor_o,
  output logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] MINUS_ONE = '1;

  rs_ctl_t       ctl;
  logic [AW-1:0] cnt_a, cnt_b, a_addr;
  logic [DW-1:0] a_rdata, b_rdata, tor_q;

  rs_ctrl u_ctrl (.op_i(op_i), .cond_i(cond_i), .ctl_o(ctl));

  // cnt_a: next free slot; cnt_b: newest stored entry (cnt_a - 1)
  rs_ptr_counter #(.AW(AW), .RST_VAL('0), .LOAD_OFS('0)) u_cnt_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ctl.push), .dec1_i(ctl.pop1),
    .dec2_i(ctl.pop2), .load_i(ctl.load), .load_val_i(sp_load_i), .cnt_o(cnt_a)
  );

  rs_ptr_counter #(.AW(AW), .RST_VAL(MINUS_ONE), .LOAD_OFS(MINUS_ONE)) u_cnt_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ctl.push), .dec1_i(ctl.pop1),
    .dec2_i(ctl.pop2), .load_i(ctl.load), .load_val_i(sp_load_i), .cnt_o(cnt_b)
  );

  // port A: push slot normally, second-newest entry on a double return
  assign a_addr = ctl.pop2 ? (cnt_a - AW'(2)) : cnt_a;

  rs_dpram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk_i(clk_i), .a_addr_i(a_addr), .a_we_i(ctl.push), .a_wdata_i(tor_q),
    .a_rdata_o(a_rdata), .b_addr_i(cnt_b), .b_rdata_o(b_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tor_q <= '0;
    else if (ctl.push) tor_q <= ip_i;
    else if (ctl.pop1) tor_q <= b_rdata;
    else if (ctl.pop2) tor_q <= a_rdata;
  end

  always_comb begin
    next_ip_o = ip_i;
    if (ctl.pop1)      next_ip_o = tor_q;
    else if (ctl.pop2) next_ip_o = b_rdata;
  end

  assign tor_o = tor_q;
  assign sp_o  = cnt_a;
endmodule

// File: rtl/rs_unit_checker.sv
module rs_unit_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_i,
  input logic          cond_i,
  input logic [DW-1:0] ip_i,
  input logic [AW-1:0] sp_load_i,
  input logic [DW-1:0] next_ip_o,
  input logic [DW-1:0] tor_o,
  input logic [AW-1:0] sp_o,
  input logic [AW-1:0] cnt_b
);
  logic ret1, ret2;
  assign ret1 = (op_i == 3'd2) || (op_i == 3'd4 && cond_i);
  assign ret2 = (op_i == 3'd3) || (op_i == 3'd5 && cond_i);

  assert_push_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd1 |=> (sp_o == AW'($past(sp_o) + 1'b1)) && (tor_o == $past(ip_i)));

  assert_ret_ip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret1 |-> next_ip_o == tor_o);

  assert_ret_sp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret1 |=> sp_o == AW'($past(sp_o) - 1'b1));

  assert_ret2_sp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret2 |=> sp_o == AW'($past(sp_o) - 2'd2));

  assert_cond_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {3'd4, 3'd5}) && !cond_i |=> $stable(tor_o) && $stable(sp_o));

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd6 |=> (sp_o == $past(sp_load_i)) && $stable(tor_o));

  assert_counter_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_b == AW'(sp_o - 1'b1));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i == 3'd7) |=> $stable(tor_o) && $stable(sp_o));

  assert_idle_ip_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret1 && !ret2 |-> next_ip_o == ip_i);
endmodule

bind rstack_unit rs_unit_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .cond_i(cond_i), .ip_i(ip_i),
  .sp_load_i(sp_load_i), .next_ip_o(next_ip_o), .tor_o(tor_o), .sp_o(sp_o),
  .cnt_b(cnt_b)
);

// File: tb/rstack_unit_bench.sv
module rstack_unit_bench;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    op_i = '0;
  logic          cond_i = 1'b0;
  logic [DW-1:0] ip_i = '0;
  logic [AW-1:0] sp_load_i = '0;
  logic [DW-1:0] next_ip_o, tor_o;
  logic [AW-1:0] sp_o;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] m_ram [DEPTH];
  logic [DW-1:0] m_tor = '0;
  logic [AW-1:0] m_sp = '0;

  always #5 clk = ~clk;

  rstack_unit #(.DW(DW), .DEPTH(DEPTH)) u_rstack_unit (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .cond_i(cond_i), .ip_i(ip_i),
    .sp_load_i(sp_load_i), .next_ip_o(next_ip_o), .tor_o(tor_o), .sp_o(sp_o)
  );

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic step(input string tag, input logic [2:0] op, input logic [DW-1:0] ip,
                      input logic c, input logic [AW-1:0] ld);
    logic [DW-1:0] exp_ip;
    logic [AW-1:0] i1, i2;
    @(negedge clk);
    op_i = op; ip_i = ip; cond_i = c; sp_load_i = ld;
    exp_ip = ip;
    i1 = m_sp - 3'd1;
    i2 = m_sp - 3'd2;
    if (op == 3'd1) begin
      m_ram[m_sp] = m_tor; m_tor = ip; m_sp = m_sp + 3'd1;
    end else if (op == 3'd2 || (op == 3'd4 && c)) begin
      exp_ip = m_tor; m_tor = m_ram[i1]; m_sp = i1;
    end else if (op == 3'd3 || (op == 3'd5 && c)) begin
      exp_ip = m_ram[i1]; m_tor = m_ram[i2]; m_sp = i2;
    end else if (op == 3'd6) begin
      m_sp = ld;
    end
    #2 chk(tag, "next_ip", next_ip_o, exp_ip);
    @(posedge clk);
    #1;
    chk(tag, "tor", tor_o, m_tor);
    chk(tag, "sp", DW'(sp_o), DW'(m_sp));
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    ip_i = 16'h1234;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "reset tor", tor_o, '0);
    chk("R1", "reset sp", DW'(sp_o), '0);
    chk("R1", "reset next_ip", next_ip_o, 16'h1234);
    @(negedge clk);
    rst_ni = 1'b1;
    #2;
    chk("R1", "post-reset tor", tor_o, '0);
    chk("R1", "post-reset sp", DW'(sp_o), '0);

    // fill every slot, then wrap the push pointer (R7)
    for (int i = 0; i < DEPTH; i++) step("R2", 3'd1, 16'h0100 + 16'(i), 1'b0, '0);
    step("R7", 3'd1, 16'h01ff, 1'b0, '0);
    step("R3", 3'd2, 16'h0, 1'b0, '0);
    step("R3", 3'd2, 16'h0, 1'b0, '0);
    step("R4", 3'd3, 16'h0, 1'b0, '0);
    step("R4", 3'd3, 16'h0, 1'b0, '0);

    // conditional forms, both condition values
    for (int c = 0; c < 2; c++) begin
      step("R2", 3'd1, 16'h0a00 + 16'(c), 1'b0, '0);
      step("R5", 3'd4, 16'h0b00, c[0], '0);
      step("R2", 3'd1, 16'h0c00 + 16'(c), 1'b0, '0);
      step("R5", 3'd5, 16'h0d00, c[0], '0);
    end

    // pointer load sweep over every value
    for (int v = 0; v < DEPTH; v++) begin
      step("R6", 3'd6, 16'h0e00, 1'b0, 3'(v));
      step("R6", 3'd3, 16'h0, 1'b0, '0);
      step("R6", 3'd2, 16'h0, 1'b0, '0);
    end

    // underflow wrap
    step("R6", 3'd6, 16'h0, 1'b0, 3'd0);
    step("R7", 3'd2, 16'h0, 1'b0, '0);
    step("R6", 3'd6, 16'h0, 1'b0, 3'd1);
    step("R7", 3'd3, 16'h0, 1'b0, '0);

    step("R8", 3'd0, 16'h5555, 1'b1, 3'd5);
    step("R8", 3'd7, 16'haaaa, 1'b1, 3'd2);

    lfsr = 16'hace1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(op_tag(lfsr[2:0]), lfsr[2:0], lfsr ^ 16'h3c3c, lfsr[5], lfsr[9:7]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule